// File: doc/BRIEF.md
# Global Counter Gate and Overflow Status Register Block

This block sits beside a bank of event counters and provides the registers that software uses to control all of them at once. A single global-enable register holds one bit per counter. Writing it starts or stops every general-purpose and fixed counter in the same clock edge, so a group of counters always covers the same interval. The counter blocks receive their bit of this register as a gate line.

Each counter reports a wrap with a one-cycle overflow pulse. The block latches these pulses in a sticky status word. Software reads the status word, handles the overflows, and then clears the bits it has handled by writing ones to a separate acknowledge register. A single level-sensitive interrupt line is high whenever a latched overflow belongs to a counter whose interrupt qualifier is set.

All three registers share a plain address/write-data/read-data bus. Reads are combinational from the address. In every register, general-purpose counter `i` occupies bit `i` and fixed counter `j` occupies bit `32+j`.

Top module: `pmu_glob_ctl`

## Requirements
- R1: After synchronous reset, the enable register, the status word, every gate output and `pmi_o` are all zero.
- R2: A write to address 0x38F loads the enable register at that clock edge. It updates every gate output together. Only implemented bits are stored: [NUM_GP-1:0] and [32+NUM_FX-1:32]. All other bits read back as zero.
- R3: An overflow pulse on general-purpose counter i sets status bit i, and a pulse on fixed counter j sets status bit 32+j. The new bit is visible at address 0x38E after the clock edge on which the pulse was sampled.
- R4: A status bit stays set over any number of cycles until it is acknowledged.
- R5: A write to address 0x390 clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R6: If an overflow pulse and an acknowledge of the same bit occur on the same clock edge, the bit is set after that edge.
- R7: Writes to the status address 0x38E have no effect on the status word.
- R8: A read of address 0x390, or of any address other than the three registers, returns zero.
- R9: `pmi_o` is high exactly when at least one status bit is set whose counter has its interrupt qualifier high. It stays high until every such bit is cleared. A set bit whose qualifier is low does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for `bus_addr` |
| ovf_gp_i | input | NUM_GP | Overflow pulses from general-purpose counters |
| ovf_fx_i | input | NUM_FX | Overflow pulses from fixed counters |
| irq_en_gp_i | input | NUM_GP | Interrupt qualifiers, general-purpose counters |
| irq_en_fx_i | input | NUM_FX | Interrupt qualifiers, fixed counters |
| gate_gp_o | output | NUM_GP | Global gate to each general-purpose counter |
| gate_fx_o | output | NUM_FX | Global gate to each fixed counter |
| pmi_o | output | 1 | Level performance-monitoring interrupt |

## Verification
The stickiness property assumes that the acknowledge register is the only path that can clear a status bit. It therefore only judges cycles with no acknowledge write. The status-write property only judges cycles with no overflow pulse, because a pulse may legally set a bit in the same cycle. The bench applies overflow pulses, qualifiers and bus writes one cycle apart, except in the deliberate same-edge overflow-and-acknowledge case. This keeps each expected value traceable to a single cause.

// File: rtl/pmu_gcs_pkg.sv
package pmu_gcs_pkg;

    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 64;
    localparam int FX_BASE = 32;

    localparam logic [ADDR_W-1:0] ADDR_STAT = 12'h38E;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 12'h38F;
    localparam logic [ADDR_W-1:0] ADDR_ACK  = 12'h390;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_ACK
    } reg_sel_t;

    typedef struct packed {
        logic              ctrl_we;
        logic              ack_we;
        logic [DATA_W-1:0] data;
    } bus_cmd_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            ADDR_CTRL: return SEL_CTRL;
            ADDR_STAT: return SEL_STAT;
            ADDR_ACK:  return SEL_ACK;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] impl_mask(input int ngp, input int nfx);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < ngp; i++) m[i] = 1'b1;
        for (int j = 0; j < nfx; j++) m[FX_BASE+j] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/pmu_gcs_enable_reg.sv
module pmu_gcs_enable_reg
    import pmu_gcs_pkg::*;
#(
    parameter logic [DATA_W-1:0] MASK = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_cmd_t          cmd,
    output logic [DATA_W-1:0] ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (cmd.ctrl_we)
            ctrl_q <= cmd.data & MASK;
    end

endmodule

// File: rtl/pmu_gcs_status.sv
module pmu_gcs_status
    import pmu_gcs_pkg::*;
#(
    parameter logic [DATA_W-1:0] MASK = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_cmd_t          cmd,
    input  logic [DATA_W-1:0] ovf_w,
    output logic [DATA_W-1:0] status_q
);

    logic [DATA_W-1:0] clr_w;
    logic [DATA_W-1:0] status_d;

    always_comb begin
        clr_w    = cmd.ack_we ? cmd.data : '0;
        // A new overflow wins over an acknowledge on the same edge.
        status_d = ((status_q & ~clr_w) | ovf_w) & MASK;
    end

    always_ff @(posedge clk) begin
        if (rst)
            status_q <= '0;
        else
            status_q <= status_d;
    end

endmodule

// File: rtl/pmu_gcs_irq.sv
module pmu_gcs_irq
    import pmu_gcs_pkg::*;
#(
    parameter int NUM_GP = 4,
    parameter int NUM_FX = 3
) (
    input  logic [DATA_W-1:0] status_q,
    input  logic [DATA_W-1:0] en_w,
    output logic              pmi
);

    localparam int NBITS = NUM_GP + NUM_FX;

    logic [NBITS-1:0] pend;

    for (genvar i = 0; i < NUM_GP; i++) begin : g_gp
        assign pend[i] = status_q[i] & en_w[i];
    end
    for (genvar j = 0; j < NUM_FX; j++) begin : g_fx
        assign pend[NUM_GP+j] = status_q[FX_BASE+j] & en_w[FX_BASE+j];
    end

    assign pmi = |pend;

endmodule

// File: rtl/pmu_glob_ctl.sv
module pmu_glob_ctl
    import pmu_gcs_pkg::*;
#(
    parameter int NUM_GP = 4,
    parameter int NUM_FX = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [11:0]       bus_addr,
    input  logic              bus_wr,
    input  logic [63:0]       bus_wdata,
    output logic [63:0]       bus_rdata,
    input  logic [NUM_GP-1:0] ovf_gp_i,
    input  logic [NUM_FX-1:0] ovf_fx_i,
    input  logic [NUM_GP-1:0] irq_en_gp_i,
    input  logic [NUM_FX-1:0] irq_en_fx_i,
    output logic [NUM_GP-1:0] gate_gp_o,
    output logic [NUM_FX-1:0] gate_fx_o,
    output logic              pmi_o
);

    localparam logic [DATA_W-1:0] MASK = impl_mask(NUM_GP, NUM_FX);

    reg_sel_t          sel;
    bus_cmd_t          cmd;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] ovf_w;
    logic [DATA_W-1:0] en_w;

    always_comb begin
        sel         = decode_addr(bus_addr);
        cmd.ctrl_we = bus_wr && (sel == SEL_CTRL);
        cmd.ack_we  = bus_wr && (sel == SEL_ACK);
        cmd.data    = bus_wdata;

        ovf_w = '0;
        ovf_w[NUM_GP-1:0]          = ovf_gp_i;
        ovf_w[FX_BASE +: NUM_FX]   = ovf_fx_i;
        en_w  = '0;
        en_w[NUM_GP-1:0]           = irq_en_gp_i;
        en_w[FX_BASE +: NUM_FX]    = irq_en_fx_i;
    end

    pmu_gcs_enable_reg #(.MASK(MASK)) u_enable (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .ctrl_q (ctrl_q)
    );

    pmu_gcs_status #(.MASK(MASK)) u_status (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .ovf_w    (ovf_w),
        .status_q (status_q)
    );

    pmu_gcs_irq #(.NUM_GP(NUM_GP), .NUM_FX(NUM_FX)) u_irq (
        .status_q (status_q),
        .en_w     (en_w),
        .pmi      (pmi_o)
    );

    assign gate_gp_o = ctrl_q[NUM_GP-1:0];
    assign gate_fx_o = ctrl_q[FX_BASE +: NUM_FX];

    always_comb begin
        case (sel)
            SEL_CTRL: bus_rdata = ctrl_q;
            SEL_STAT: bus_rdata = status_q;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pmu_glob_ctl_chk.sv
module pmu_glob_ctl_chk
    import pmu_gcs_pkg::*;
#(
    parameter int NUM_GP = 4,
    parameter int NUM_FX = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [11:0]       bus_addr,
    input logic              bus_wr,
    input logic [63:0]       bus_wdata,
    input logic [63:0]       bus_rdata,
    input logic [NUM_GP-1:0] ovf_gp_i,
    input logic [NUM_FX-1:0] ovf_fx_i,
    input logic [NUM_GP-1:0] irq_en_gp_i,
    input logic [NUM_FX-1:0] irq_en_fx_i,
    input logic [NUM_GP-1:0] gate_gp_o,
    input logic [NUM_FX-1:0] gate_fx_o,
    input logic              pmi_o,
    input logic [63:0]       status_q
);

    logic [63:0] ovf_v;
    logic [63:0] en_v;
    logic        ack_wr;
    logic        ctrl_wr;
    logic        stat_wr;

    always_comb begin
        ovf_v = '0;
        ovf_v[NUM_GP-1:0]        = ovf_gp_i;
        ovf_v[FX_BASE +: NUM_FX] = ovf_fx_i;
        en_v  = '0;
        en_v[NUM_GP-1:0]         = irq_en_gp_i;
        en_v[FX_BASE +: NUM_FX]  = irq_en_fx_i;
        ack_wr  = bus_wr && (bus_addr == ADDR_ACK);
        ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
        stat_wr = bus_wr && (bus_addr == ADDR_STAT);
    end

    // R2
    ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (gate_gp_o == $past(bus_wdata[NUM_GP-1:0]))
                 && (gate_fx_o == $past(bus_wdata[FX_BASE +: NUM_FX])));

    // R3
    ovf_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_v != '0) |=> ((status_q & $past(ovf_v)) == $past(ovf_v)));

    // R4
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !ack_wr |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R7
    stat_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && ovf_v == '0) |=> $stable(status_q));

    // R8
    ack_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_ACK) |-> (bus_rdata == '0));

    // R9
    pmi_cause_chk: assert property (@(posedge clk) disable iff (rst)
        pmi_o |-> ((status_q & en_v) != '0));

    // R9
    pmi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((status_q & en_v) != '0) |-> pmi_o);

endmodule

bind pmu_glob_ctl pmu_glob_ctl_chk #(.NUM_GP(NUM_GP), .NUM_FX(NUM_FX)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .ovf_gp_i    (ovf_gp_i),
    .ovf_fx_i    (ovf_fx_i),
    .irq_en_gp_i (irq_en_gp_i),
    .irq_en_fx_i (irq_en_fx_i),
    .gate_gp_o   (gate_gp_o),
    .gate_fx_o   (gate_fx_o),
    .pmi_o       (pmi_o),
    .status_q    (status_q)
);

// File: tb/pmu_glob_ctl_bench.sv
module pmu_glob_ctl_bench;

    localparam int NGP = 4;
    localparam int NFX = 3;
    localparam logic [63:0] IMPL = 64'h0000_0007_0000_000F;
    localparam logic [11:0] A_STAT = 12'h38E;
    localparam logic [11:0] A_CTRL = 12'h38F;
    localparam logic [11:0] A_ACK  = 12'h390;

    localparam int K_RDATA = 0;
    localparam int K_PMI   = 1;
    localparam int K_GATE  = 2;

    typedef struct {
        int          kind;
        logic [63:0] exp;
        string       tag;
    } item_t;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [11:0]    bus_addr = '0;
    logic           bus_wr = 1'b0;
    logic [63:0]    bus_wdata = '0;
    logic [63:0]    bus_rdata;
    logic [NGP-1:0] ovf_gp = '0;
    logic [NFX-1:0] ovf_fx = '0;
    logic [NGP-1:0] en_gp = '0;
    logic [NFX-1:0] en_fx = '0;
    logic [NGP-1:0] gate_gp;
    logic [NFX-1:0] gate_fx;
    logic           pmi;

    logic  sample_req = 1'b0;
    item_t sb_q[$];
    int    n_run  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    always #4 clk = ~clk;

    pmu_glob_ctl #(.NUM_GP(NGP), .NUM_FX(NFX)) u_pmu_glob_ctl (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .ovf_gp_i    (ovf_gp),
        .ovf_fx_i    (ovf_fx),
        .irq_en_gp_i (en_gp),
        .irq_en_fx_i (en_fx),
        .gate_gp_o   (gate_gp),
        .gate_fx_o   (gate_fx),
        .pmi_o       (pmi)
    );

    // Monitor: samples 2 ns after the edge that follows each request.
    initial begin
        logic [63:0] act;
        item_t it;
        forever begin
            @(posedge clk);
            #2;
            if (sample_req && sb_q.size() > 0) begin
                it = sb_q.pop_front();
                act = '0;
                case (it.kind)
                    K_RDATA: act = bus_rdata;
                    K_PMI:   act[0] = pmi;
                    default: begin
                        act[NGP-1:0] = gate_gp;
                        act[32 +: NFX] = gate_fx;
                    end
                endcase
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    // One bus/overflow cycle, driven between falling edges.
    task automatic drive(input logic wr, input logic [11:0] a, input logic [63:0] d,
                         input logic [NGP-1:0] og, input logic [NFX-1:0] of);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; ovf_gp = og; ovf_fx = of;
        @(negedge clk);
        bus_wr = 1'b0; ovf_gp = '0; ovf_fx = '0;
    endtask

    task automatic expect_item(input int kind, input logic [11:0] a,
                               input logic [63:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        sample_req = 1'b1;
        @(negedge clk);
        sample_req = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_item(K_RDATA, A_CTRL, 64'h0, "R1 ctrl after reset");
        expect_item(K_RDATA, A_STAT, 64'h0, "R1 status after reset");
        expect_item(K_GATE,  A_CTRL, 64'h0, "R1 gates after reset");
        expect_item(K_PMI,   A_CTRL, 64'h0, "R1 pmi after reset");

        // R2 global gate load, masking, group stop
        drive(1'b1, A_CTRL, '1, '0, '0);
        expect_item(K_RDATA, A_CTRL, IMPL, "R2 ctrl masked readback");
        expect_item(K_GATE,  A_CTRL, IMPL, "R2 all gates on together");
        drive(1'b1, A_CTRL, 64'h0000_0001_0000_0005, '0, '0);
        expect_item(K_GATE,  A_CTRL, 64'h0000_0001_0000_0005, "R2 partial gate pattern");
        drive(1'b1, A_CTRL, 64'h0, '0, '0);
        expect_item(K_GATE,  A_CTRL, 64'h0, "R2 all gates off together");

        // R3 overflow latching and bit mapping
        drive(1'b0, A_STAT, '0, 4'b0010, 3'b100);
        expect_item(K_RDATA, A_STAT, 64'h0000_0004_0000_0002, "R3 gp1 and fx2 latched");

        // R9 qualifier low: no interrupt
        expect_item(K_PMI, A_STAT, 64'h0, "R9 no pmi with qualifiers low");

        // R4 sticky across idle cycles
        repeat (5) @(negedge clk);
        expect_item(K_RDATA, A_STAT, 64'h0000_0004_0000_0002, "R4 status held");

        // R7 status writes ignored
        drive(1'b1, A_STAT, '1, '0, '0);
        expect_item(K_RDATA, A_STAT, 64'h0000_0004_0000_0002, "R7 status write ignored");
        drive(1'b1, A_STAT, 64'h0, '0, '0);
        expect_item(K_RDATA, A_STAT, 64'h0000_0004_0000_0002, "R7 status zero write ignored");

        // R8 ack and unmapped reads
        expect_item(K_RDATA, A_ACK, 64'h0, "R8 ack reads zero");
        expect_item(K_RDATA, 12'h123, 64'h0, "R8 unmapped reads zero");

        // R9 interrupt with qualifiers
        @(negedge clk); en_gp = 4'b0010; en_fx = 3'b100;
        expect_item(K_PMI, A_STAT, 64'h1, "R9 pmi with two pending");

        // R5 partial acknowledge; R9 holds while one pending remains
        drive(1'b1, A_ACK, 64'h0000_0000_0000_0002, '0, '0);
        expect_item(K_RDATA, A_STAT, 64'h0000_0004_0000_0000, "R5 gp1 cleared fx2 kept");
        expect_item(K_PMI,   A_STAT, 64'h1, "R9 pmi held while fx2 pending");
        drive(1'b1, A_ACK, 64'h0000_0004_0000_0000, '0, '0);
        expect_item(K_RDATA, A_STAT, 64'h0, "R5 fx2 cleared");
        expect_item(K_PMI,   A_STAT, 64'h0, "R9 pmi drops when all cleared");

        // R6 overflow and acknowledge on the same edge
        drive(1'b0, A_STAT, '0, 4'b0001, 3'b000);
        drive(1'b1, A_ACK, 64'h1, 4'b0001, 3'b000);
        expect_item(K_RDATA, A_STAT, 64'h1, "R6 same-edge set wins");
        drive(1'b1, A_ACK, 64'h1, '0, '0);
        expect_item(K_RDATA, A_STAT, 64'h0, "R5 bit0 cleared afterwards");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule